// File: doc/BRIEF.md
# Unaligned Store Gate

This block sits between a processor's store port and an aligned write channel. Each accepted store is classified from its address, its size and the memory type of the target region. The block then either forwards it as a single aligned write beat, breaks it into two aligned beats, or rejects it with a fault pulse and writes nothing to the bus. The decision uses a software-writable control word: when its alignment-check bit is set, every misaligned store is refused.

Misaligned stores to normal memory are allowed while the check bit is clear. They are never dropped. When the bytes fit inside one bus word, one beat goes out with the data moved to the addressed byte lanes. When they run past the end of a word, the lower word goes out first and the next word follows. Misaligned stores to device or strongly-ordered regions are always refused. Aligned stores are never refused.

The sequencer has four states:
- `SEQ_IDLE` takes requests.
- `SEQ_LOW` presents the lower (or only) beat.
- `SEQ_HIGH` presents the upper beat of a split store.
- `SEQ_FAULT` raises the fault pulse.

Its transitions are:
- IDLE→FAULT on a refused request.
- IDLE→LOW on an allowed one.
- LOW→HIGH when a split lower beat is taken.
- LOW→IDLE when an unsplit beat is taken.
- HIGH→IDLE when the upper beat is taken.
- FAULT→IDLE always.

Top module: `store_align_gate`

## Requirements
- R1: After reset, `ctl_rd_data` is 0, `req_ready` is 1, and both `bus_valid` and `fault_pulse` are 0.
- R2: A cycle with `ctl_wr_en` high loads the whole of `ctl_wr_data` into the control word, and `ctl_rd_data` shows it from the next cycle. Only bit 1 (the alignment-check bit) affects behaviour; every other bit is stored and has no effect.
- R3: A store is misaligned when its address is not a multiple of its byte count. An aligned store is always allowed for every memory type. It produces exactly one beat with address `req_addr` with the low two bits cleared. The strobes cover only the addressed bytes, and byte k of `req_data` appears on lane (address+k) mod 4.
- R4: While the check bit is 0, a misaligned store to normal memory (`req_mtype` 00) is allowed. It is delivered as aligned beats and is never dropped.
- R5: While the check bit is 1, every misaligned store produces a fault pulse and no beat.
- R6: A misaligned store to device memory (`req_mtype` 01) faults whatever the check bit is. The same holds for strongly-ordered memory (`req_mtype` 10) and for the code 11, which is treated as strongly-ordered.
- R7: An allowed store whose bytes cross a 4-byte word boundary produces two beats in ascending address order, the second at the first address plus 4. Each beat's strobes cover only the bytes written in that word, and each beat's data sits on the matching lanes. A store that does not cross a word boundary produces one beat.
- R8: A fault is a pulse exactly one cycle long. `req_ready` returns high in the cycle after it.
- R9: `req_ready` is low from the cycle after a request is accepted until the cycle after its last beat is accepted (`bus_valid` and `bus_ready` both high). While a beat waits for `bus_ready`, its address, strobes and data stay unchanged.
- R10: `req_size` encodes the byte count: 00 is 1 byte, 01 is 2 bytes, and 10 or 11 is 4 bytes. A 1-byte store is never misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control word write enable |
| ctl_wr_data | input | 32 | Control word write value (bit 1 = alignment check) |
| ctl_rd_data | output | 32 | Current control word |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Store request ready |
| req_addr | input | ADDR_W | Store byte address |
| req_size | input | 2 | Store size code |
| req_mtype | input | 2 | Memory type of target region |
| req_data | input | 8*BUS_BYTES | Store data, byte 0 in the low lane |
| bus_valid | output | 1 | Write beat valid |
| bus_ready | input | 1 | Write beat accepted |
| bus_addr | output | ADDR_W | Word-aligned beat address |
| bus_strb | output | BUS_BYTES | Beat byte strobes |
| bus_data | output | 8*BUS_BYTES | Beat data on byte lanes |
| fault_pulse | output | 1 | One-cycle alignment fault |

## Verification
The bench builds the block with its defaults: a 32-bit address and a 4-byte bus word. With these, every start lane from 0 to 3 can be combined with every size code, so the checks reach each crossing shape: a word that spans two words at each offset, and a halfword that straddles lanes 3 and 0. They also reach a crossing store near the top of the address space, where the second word address wraps. Random stores mix all four memory-type codes with random toggling of the check bit and random back-pressure on `bus_ready`. This exercises the hold rule and the ordering of split beats under stalls.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LOW   = 2'd1,
        SEQ_HIGH  = 2'd2,
        SEQ_FAULT = 2'd3
    } seq_state_e;

    localparam logic [1:0] MEM_NORMAL = 2'b00;
    localparam logic [1:0] MEM_DEVICE = 2'b01;
    localparam logic [1:0] MEM_STRONG = 2'b10;

    localparam int CTL_W   = 32;
    localparam int CHK_BIT = 1;

    // size code to byte count: 00->1, 01->2, 1x->4
    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'b00:   n = 3'd1;
            2'b01:   n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sag_ctrl_reg.sv
module sag_ctrl_reg
    import sag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] value,
    output logic             chk_en
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (wr_en)
            value <= wr_data;
    end

    assign chk_en = value[CHK_BIT];

    // R2: a write lands in the register one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> value == $past(wr_data));

endmodule

// File: rtl/sag_classify.sv
module sag_classify
    import sag_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [1:0]             size,
    input  logic [1:0]             mtype,
    input  logic [8*BUS_BYTES-1:0] data,
    input  logic                   chk_en,
    output logic                   fault,
    output logic                   split,
    output logic [ADDR_W-1:0]      word_addr,
    output logic [BUS_BYTES-1:0]   strb_lo,
    output logic [BUS_BYTES-1:0]   strb_hi,
    output logic [8*BUS_BYTES-1:0] data_lo,
    output logic [8*BUS_BYTES-1:0] data_hi
);

    localparam int OFF_W  = $clog2(BUS_BYTES);
    localparam int DATA_W = 8 * BUS_BYTES;
    localparam int SPAN   = 2 * BUS_BYTES;

    logic [2:0]          nbytes;
    logic [OFF_W-1:0]    offset;
    logic [OFF_W-1:0]    size_mask;
    logic                misaligned;
    logic [BUS_BYTES-1:0] lane_bits;
    logic [DATA_W-1:0]   data_keep;
    logic [SPAN-1:0]     span_strb;
    logic [2*DATA_W-1:0] span_data;

    always_comb begin
        nbytes     = size_to_bytes(size);
        offset     = addr[OFF_W-1:0];
        size_mask  = OFF_W'(nbytes - 3'd1);
        misaligned = |(offset & size_mask);
        for (int i = 0; i < BUS_BYTES; i++) begin
            lane_bits[i]        = (int'(nbytes) > i);
            data_keep[8*i +: 8] = lane_bits[i] ? data[8*i +: 8] : 8'h00;
        end
        span_strb = {{BUS_BYTES{1'b0}}, lane_bits} << offset;
        span_data = {{DATA_W{1'b0}}, data_keep} << {offset, 3'b000};
    end

    assign fault     = misaligned && (chk_en || (mtype != MEM_NORMAL));
    assign split     = |span_strb[SPAN-1:BUS_BYTES];
    assign word_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign strb_lo   = span_strb[BUS_BYTES-1:0];
    assign strb_hi   = span_strb[SPAN-1:BUS_BYTES];
    assign data_lo   = span_data[DATA_W-1:0];
    assign data_hi   = span_data[2*DATA_W-1:DATA_W];

endmodule

// File: rtl/sag_seq.sv
module sag_seq
    import sag_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   dec_fault,
    input  logic                   dec_split,
    input  logic [ADDR_W-1:0]      dec_addr,
    input  logic [BUS_BYTES-1:0]   dec_strb_lo,
    input  logic [BUS_BYTES-1:0]   dec_strb_hi,
    input  logic [8*BUS_BYTES-1:0] dec_data_lo,
    input  logic [8*BUS_BYTES-1:0] dec_data_hi,
    output logic                   bus_valid,
    input  logic                   bus_ready,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [BUS_BYTES-1:0]   bus_strb,
    output logic [8*BUS_BYTES-1:0] bus_data,
    output logic                   fault_pulse
);

    localparam int DATA_W = 8 * BUS_BYTES;

    seq_state_e           state, state_nx;
    logic                 lat_split;
    logic [ADDR_W-1:0]    lat_addr;
    logic [BUS_BYTES-1:0] lat_strb_lo, lat_strb_hi;
    logic [DATA_W-1:0]    lat_data_lo, lat_data_hi;
    logic                 take_req;

    assign take_req = (state == SEQ_IDLE) && req_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:  if (req_valid) state_nx = dec_fault ? SEQ_FAULT : SEQ_LOW;
            SEQ_LOW:   if (bus_ready) state_nx = lat_split ? SEQ_HIGH : SEQ_IDLE;
            SEQ_HIGH:  if (bus_ready) state_nx = SEQ_IDLE;
            SEQ_FAULT: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEQ_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_split   <= 1'b0;
            lat_addr    <= '0;
            lat_strb_lo <= '0;
            lat_strb_hi <= '0;
            lat_data_lo <= '0;
            lat_data_hi <= '0;
        end else if (take_req) begin
            lat_split   <= dec_split;
            lat_addr    <= dec_addr;
            lat_strb_lo <= dec_strb_lo;
            lat_strb_hi <= dec_strb_hi;
            lat_data_lo <= dec_data_lo;
            lat_data_hi <= dec_data_hi;
        end
    end

    always_comb begin
        req_ready   = 1'b0;
        bus_valid   = 1'b0;
        fault_pulse = 1'b0;
        bus_addr    = lat_addr;
        bus_strb    = lat_strb_lo;
        bus_data    = lat_data_lo;
        unique case (state)
            SEQ_IDLE:  req_ready = 1'b1;
            SEQ_LOW:   bus_valid = 1'b1;
            SEQ_HIGH: begin
                bus_valid = 1'b1;
                bus_addr  = lat_addr + ADDR_W'(BUS_BYTES);
                bus_strb  = lat_strb_hi;
                bus_data  = lat_data_hi;
            end
            SEQ_FAULT: fault_pulse = 1'b1;
        endcase
    end

    // R8: fault lasts one cycle
    a_r8_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> !fault_pulse);

    // R8: ready returns right after a fault
    a_r8_ready_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> req_ready);

    // R5: a fault never comes with a bus write
    a_r5_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> !bus_valid);

    // R9: no new request while a beat is pending
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

    // R9: a stalled beat holds its payload
    a_r9_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                       && $stable(bus_strb) && $stable(bus_data)));

    // R7: upper beat follows at the next word address
    a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_LOW && bus_ready && lat_split)
            |=> (bus_valid && bus_addr == $past(bus_addr) + ADDR_W'(BUS_BYTES)));

    // R3: every beat writes at least one byte
    a_r3_strobe_present: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_strb != '0));

endmodule

// File: rtl/store_align_gate.sv
module store_align_gate
    import sag_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr_en,
    input  logic [31:0]            ctl_wr_data,
    output logic [31:0]            ctl_rd_data,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [1:0]             req_size,
    input  logic [1:0]             req_mtype,
    input  logic [8*BUS_BYTES-1:0] req_data,
    output logic                   bus_valid,
    input  logic                   bus_ready,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [BUS_BYTES-1:0]   bus_strb,
    output logic [8*BUS_BYTES-1:0] bus_data,
    output logic                   fault_pulse
);

    localparam int DATA_W = 8 * BUS_BYTES;

    logic                 chk_en;
    logic                 dec_fault, dec_split;
    logic [ADDR_W-1:0]    dec_addr;
    logic [BUS_BYTES-1:0] dec_strb_lo, dec_strb_hi;
    logic [DATA_W-1:0]    dec_data_lo, dec_data_hi;

    sag_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .value   (ctl_rd_data),
        .chk_en  (chk_en)
    );

    sag_classify #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_class (
        .addr      (req_addr),
        .size      (req_size),
        .mtype     (req_mtype),
        .data      (req_data),
        .chk_en    (chk_en),
        .fault     (dec_fault),
        .split     (dec_split),
        .word_addr (dec_addr),
        .strb_lo   (dec_strb_lo),
        .strb_hi   (dec_strb_hi),
        .data_lo   (dec_data_lo),
        .data_hi   (dec_data_hi)
    );

    sag_seq #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .dec_fault   (dec_fault),
        .dec_split   (dec_split),
        .dec_addr    (dec_addr),
        .dec_strb_lo (dec_strb_lo),
        .dec_strb_hi (dec_strb_hi),
        .dec_data_lo (dec_data_lo),
        .dec_data_hi (dec_data_hi),
        .bus_valid   (bus_valid),
        .bus_ready   (bus_ready),
        .bus_addr    (bus_addr),
        .bus_strb    (bus_strb),
        .bus_data    (bus_data),
        .fault_pulse (fault_pulse)
    );

    // R6: a misaligned store to a non-normal region is refused at accept
    a_r6_nonnormal_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mtype != MEM_NORMAL
         && req_size != 2'b00 && req_addr[0]) |=> fault_pulse);

endmodule

// File: tb/store_align_gate_tb_top.sv
module store_align_gate_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic [31:0] ctl_rd_data;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_mtype = '0;
    logic [31:0] req_data = '0;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_addr;
    logic [3:0]  bus_strb;
    logic [31:0] bus_data;
    logic        fault_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit chk_model = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_align_gate dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_mtype(req_mtype), .req_data(req_data),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_strb(bus_strb), .bus_data(bus_data), .fault_pulse(fault_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int n_of(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
    endfunction

    task automatic ctl_write(input logic [31:0] v);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = v;
        @(negedge clk);
        ctl_wr_en = 1'b0;
        chk_model = v[1];
        check(ctl_rd_data == v, "R2", "control readback", ctl_rd_data, v);
    endtask

    task automatic do_store(input logic [31:0] a, input logic [1:0] sz,
                            input logic [1:0] mt, input logic [31:0] d,
                            input int stall_pct);
        int n;
        bit unal, exp_fault;
        int exp_beats;
        logic [31:0] e_addr [2];
        logic [3:0]  e_strb [2];
        logic [31:0] e_data [2];
        logic [31:0] g_addr [2];
        logic [3:0]  g_strb [2];
        logic [31:0] g_data [2];
        int beats, faults;
        logic [31:0] m;
        n = n_of(sz);
        unal = (a % n) != 0;
        exp_fault = unal && (chk_model || mt != 2'b00);
        for (int b = 0; b < 2; b++) begin
            e_strb[b] = '0; e_data[b] = '0; g_addr[b] = '0; g_strb[b] = '0; g_data[b] = '0;
        end
        e_addr[0] = a & ~32'h3;
        e_addr[1] = e_addr[0] + 32'd4;
        for (int i = 0; i < n; i++) begin
            logic [31:0] ba;
            int w, lane;
            ba = a + 32'(i);
            w = ((ba & ~32'h3) == e_addr[0]) ? 0 : 1;
            lane = int'(ba[1:0]);
            e_strb[w][lane] = 1'b1;
            e_data[w][8*lane +: 8] = d[8*i +: 8];
        end
        exp_beats = exp_fault ? 0 : ((e_strb[1] != 0) ? 2 : 1);

        @(negedge clk);
        check(req_ready == 1'b1, "R9", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_mtype = mt; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        beats = 0; faults = 0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            if (cyc > 0 && req_ready) break;
            if (cyc == 0)
                check(req_ready == 1'b0, "R9", "ready low after accept", 32'(req_ready), 32'd0);
            bus_ready = ($urandom_range(0, 99) >= stall_pct);
            if (fault_pulse) faults++;
            if (bus_valid && bus_ready) begin
                if (beats < 2) begin
                    g_addr[beats] = bus_addr; g_strb[beats] = bus_strb; g_data[beats] = bus_data;
                end
                beats++;
            end
            @(negedge clk);
        end
        bus_ready = 1'b0;
        check(faults == (exp_fault ? 1 : 0), exp_fault ? (mt != 0 ? "R6" : "R5") : "R8",
              "fault pulse count", 32'(faults), exp_fault ? 32'd1 : 32'd0);
        check(beats == exp_beats, unal ? (exp_fault ? "R5" : "R4") : "R3",
              "beat count", 32'(beats), 32'(exp_beats));
        for (int b = 0; b < 2; b++) begin
            if (b < exp_beats && b < beats) begin
                m = {{8{e_strb[b][3]}}, {8{e_strb[b][2]}}, {8{e_strb[b][1]}}, {8{e_strb[b][0]}}};
                check(g_addr[b] == e_addr[b], exp_beats == 2 ? "R7" : "R3", "beat address",
                      g_addr[b], e_addr[b]);
                check(g_strb[b] == e_strb[b], exp_beats == 2 ? "R7" : "R3", "beat strobes",
                      32'(g_strb[b]), 32'(e_strb[b]));
                check((g_data[b] & m) == e_data[b], exp_beats == 2 ? "R7" : "R3", "beat data",
                      g_data[b] & m, e_data[b]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ctl_rd_data == 32'h0, "R1", "control after reset", ctl_rd_data, 32'h0);
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        check(bus_valid == 1'b0, "R1", "bus_valid after reset", 32'(bus_valid), 32'd0);
        check(fault_pulse == 1'b0, "R1", "fault after reset", 32'(fault_pulse), 32'd0);

        // R3 aligned stores on every memory type
        do_store(32'h1000_0000, 2'b10, 2'b01, 32'hA1B2C3D4, 0);
        do_store(32'h1000_0002, 2'b01, 2'b10, 32'h0000BEEF, 0);
        do_store(32'h1000_0003, 2'b00, 2'b11, 32'h000000E7, 30);
        // R4/R7 permitted misaligned word, splits at each offset
        do_store(32'hFC00_0001, 2'b10, 2'b00, 32'h11223344, 0);
        do_store(32'hFC00_0002, 2'b10, 2'b00, 32'h55667788, 50);
        do_store(32'hFC00_0003, 2'b10, 2'b00, 32'h99AABBCC, 50);
        // R7 halfword straddling lanes 3 and 0, R4 halfword not crossing
        do_store(32'h2000_0007, 2'b01, 2'b00, 32'h0000CAFE, 0);
        do_store(32'h2000_0005, 2'b01, 2'b00, 32'h0000F00D, 0);
        // R10 code 11 is 4 bytes; R7 wrap at top of space
        do_store(32'h3000_0002, 2'b11, 2'b00, 32'hDEADBEEF, 0);
        do_store(32'hFFFF_FFFE, 2'b10, 2'b00, 32'h0BADF00D, 0);
        // R6 non-normal misaligned faults with check off
        do_store(32'h4000_0001, 2'b10, 2'b01, 32'h12345678, 0);
        do_store(32'h4000_0001, 2'b01, 2'b10, 32'h12345678, 0);
        do_store(32'h4000_0003, 2'b10, 2'b11, 32'h12345678, 0);
        // R5 check on: normal misaligned faults, aligned still passes
        ctl_write(32'h0000_0002);
        do_store(32'hFC00_0001, 2'b10, 2'b00, 32'h11223344, 0);
        do_store(32'hFC00_0004, 2'b10, 2'b00, 32'h11223344, 0);
        // R2 other bits ignored: bit 1 clear, rest set, permits misaligned
        ctl_write(32'hFFFF_FFFD);
        do_store(32'hFC00_0001, 2'b10, 2'b00, 32'h11223344, 0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 9) == 0)
                ctl_write($urandom());
            do_store($urandom(), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                     $urandom(), int'($urandom_range(0, 60)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule